// File: doc/BRIEF.md
# Keyboard Pin Interrupt Controller

This block watches a group of port input pins (eight by default) and raises a single interrupt request when an enabled pin shows its active edge. Each pin has its own enable and polarity bits. One mode bit, shared by all pins, selects plain edge detection or edge detection followed by level holding. In the level-holding mode, the pending flag cannot be cleared while any enabled pin still sits at its active level.

The raw pins first pass through a two-stage synchronizer. Edges are then found by comparing synchronized samples on consecutive clock cycles. A pin has to be seen at its inactive level before an edge on it counts. This stops a pin that is already active at enable time, or after a polarity change, from firing a false event. A found event sets a sticky pending flag. The acknowledge strobe clears it. The request line is the flag gated by an interrupt enable bit. All control inputs are plain level signals. The block has no data stream, so it has no valid/ready handshake.

Top module: `kbd_pin_irq`

## Requirements
- R1: A pin whose bit in `pin_en` is 0 never sets `pend`, whatever its input does.
- R2: Pin inputs are synchronized by two flops before comparison. A pin change that is stable before rising clock edge k shows on `pend` after rising edge k+2, and not before.
- R3: Polarity bit 0 makes a pin active on a 1-to-0 transition (and low level). Polarity bit 1 makes it active on a 0-to-1 transition (and high level).
- R4: An edge counts only if the synchronized pin was at its inactive level on the previous cycle while enabled. A pin that is already active when it is enabled, or when reset is released, sets nothing until it has gone inactive and then active again.
- R5: `pend` is sticky. In edge mode (`level_mode`=0), an `ack` pulse with no new edge in that cycle clears it on the next clock, even if the pin stays active.
- R6: `irq` equals `pend` when `irq_en` is 1 and is 0 when `irq_en` is 0.
- R7: In level mode (`level_mode`=1), `ack` does not clear `pend` while any enabled synchronized pin is at its active level. Once all enabled pins are inactive, `ack` clears it.
- R8: When `ack` and a new edge fall in the same cycle, the edge wins and `pend` stays 1.
- R9: Changing a pin's enable or polarity bit never by itself produces an event. The pin must first be sampled inactive under the new setting.
- R10: After reset, `pend` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | NUM_PINS | Raw asynchronous pin inputs |
| pin_en | input | NUM_PINS | Per-pin enable |
| pin_pol | input | NUM_PINS | Per-pin polarity (0 falling/low, 1 rising/high) |
| level_mode | input | 1 | 0 edge only, 1 edge then level hold |
| irq_en | input | 1 | Interrupt request enable |
| ack | input | 1 | Acknowledge strobe, clears the pending flag |
| pend | output | 1 | Sticky pending flag |
| irq | output | 1 | Interrupt request |

## Verification
A stale arming bit or a wrong previous sample shows at the ports as a missing or extra rise of `pend`. The rise is expected exactly three clock edges after the pin changes, so an error shows within three cycles of the stimulus. A flag-update error shows one cycle after an `ack`: `pend` either clears while a level is still held, or stays set when it should clear. The directed scenarios aim each stimulus at one of these cycle-exact observation points.

// File: rtl/kbd_pin_irq_pkg.sv
package kbd_pin_irq_pkg;

  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_LEVEL = 1'b1
  } det_mode_e;

  // Map a synchronized sample onto "active" given the polarity bit.
  function automatic logic is_active(input logic sample, input logic pol);
    return pol ? sample : ~sample;
  endfunction

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];

endmodule

// File: rtl/kbd_pin_detect.sv
module kbd_pin_detect
  import kbd_pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sample,
  input  logic [NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0] pol,
  output logic [NUM_PINS-1:0] edge_hit,
  output logic [NUM_PINS-1:0] level_hit
);

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic act;
      logic armed_q;
      logic en_q;
      logic pol_q;
      logic cfg_chg;

      assign act     = is_active(sample[p], pol[p]);
      assign cfg_chg = (en[p] != en_q) || (pol[p] != pol_q);

      // armed_q: last cycle this pin was enabled and seen inactive.
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          armed_q <= 1'b0;
          en_q    <= 1'b0;
          pol_q   <= 1'b0;
        end else begin
          armed_q <= en[p] && !act;
          en_q    <= en[p];
          pol_q   <= pol[p];
        end
      end

      assign edge_hit[p]  = en[p] && !cfg_chg && armed_q && act;
      assign level_hit[p] = en[p] && act;
    end
  endgenerate

endmodule

// File: rtl/kbd_pend_flag.sv
module kbd_pend_flag
  import kbd_pin_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  det_mode_e mode,
  input  logic      edge_any,
  input  logic      level_any,
  input  logic      ack,
  output logic      pend
);

  logic hold;
  logic clr;
  logic pend_d;

  assign hold   = (mode == DET_LEVEL) && level_any;
  assign clr    = ack && !hold;
  assign pend_d = edge_any || (pend && !clr);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

endmodule

// File: rtl/kbd_pin_irq.sv
module kbd_pin_irq
  import kbd_pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS-1:0] pin_en,
  input  logic [NUM_PINS-1:0] pin_pol,
  input  logic                level_mode,
  input  logic                irq_en,
  input  logic                ack,
  output logic                pend,
  output logic                irq
);

  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] edge_vec;
  logic [NUM_PINS-1:0] lvl_vec;
  logic                edge_any;
  logic                lvl_any;
  det_mode_e           mode;

  assign mode = det_mode_e'(level_mode);

  kbd_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_raw),
    .q_sync  (pin_s)
  );

  kbd_pin_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (pin_s),
    .en        (pin_en),
    .pol       (pin_pol),
    .edge_hit  (edge_vec),
    .level_hit (lvl_vec)
  );

  assign edge_any = |edge_vec;
  assign lvl_any  = |lvl_vec;

  kbd_pend_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .edge_any  (edge_any),
    .level_any (lvl_any),
    .ack       (ack),
    .pend      (pend)
  );

  assign irq = pend && irq_en;

endmodule

// File: rtl/kbd_pin_irq_chk.sv
module kbd_pin_irq_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_en,
  input logic                level_mode,
  input logic                irq_en,
  input logic                ack,
  input logic                pend,
  input logic                irq,
  input logic                edge_any,
  input logic                lvl_any
);

  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);                                                  // R6
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);                                                      // R6
  AST_NO_EN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en == '0) && !pend |=> !pend);                                 // R1
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !ack |=> pend);                                             // R5
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend && ack && !edge_any && !(level_mode && lvl_any) |=> !pend);   // R5
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && level_mode && lvl_any |=> pend);                            // R7
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ack && edge_any |=> pend);                                          // R8

endmodule

bind kbd_pin_irq kbd_pin_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_en     (pin_en),
  .level_mode (level_mode),
  .irq_en     (irq_en),
  .ack        (ack),
  .pend       (pend),
  .irq        (irq),
  .edge_any   (edge_any),
  .lvl_any    (lvl_any)
);

// File: tb/kbd_pin_irq_bench.sv
module kbd_pin_irq_bench;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_raw, pin_en, pin_pol;
  logic         level_mode, irq_en, ack;
  logic         pend, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  kbd_pin_irq #(.NUM_PINS(N)) u_kbd_pin_irq (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pin_en(pin_en),
    .pin_pol(pin_pol), .level_mode(level_mode), .irq_en(irq_en),
    .ack(ack), .pend(pend), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_raw = '0; pin_en = '0; pin_pol = '0;
    level_mode = 1'b0; irq_en = 1'b1; ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(pend, 1'b0, "R10 pend after reset");
    chk(irq, 1'b0, "R10 irq after reset");
  endtask

  task automatic t_falling_latency();
    do_reset();
    pin_raw[0] = 1'b1; pin_en[0] = 1'b1;
    tick(4);
    pin_raw[0] = 1'b0;
    tick(2);
    chk(pend, 1'b0, "R2 no pend before third edge");
    tick(1);
    chk(pend, 1'b1, "R2 R3 falling edge sets pend");
    chk(irq, 1'b1, "R6 irq follows pend");
  endtask

  task automatic t_edge_ack();
    t_falling_latency();
    pulse_ack();
    chk(pend, 1'b0, "R5 ack clears in edge mode with pin held");
    tick(4);
    chk(pend, 1'b0, "R5 held pin does not re-set");
  endtask

  task automatic t_disabled();
    do_reset();
    pin_raw[4] = 1'b1;
    tick(3);
    pin_raw[4] = 1'b0;
    tick(3);
    pin_raw[4] = 1'b1;
    tick(3);
    pin_raw[4] = 1'b0;
    tick(4);
    chk(pend, 1'b0, "R1 disabled pin toggling");
  endtask

  task automatic t_rising();
    do_reset();
    pin_pol[3] = 1'b1; pin_en[3] = 1'b1;
    tick(4);
    pin_raw[3] = 1'b1;
    tick(3);
    chk(pend, 1'b1, "R3 rising edge with polarity 1");
    pulse_ack();
    pin_raw[3] = 1'b0;
    tick(4);
    chk(pend, 1'b0, "R3 falling edge ignored with polarity 1");
  endtask

  task automatic t_already_active();
    do_reset();
    pin_raw[5] = 1'b1; pin_pol[5] = 1'b1;
    tick(4);
    pin_en[5] = 1'b1;
    tick(5);
    chk(pend, 1'b0, "R4 active at enable sets nothing");
    pin_raw[5] = 1'b0;
    tick(4);
    pin_raw[5] = 1'b1;
    tick(3);
    chk(pend, 1'b1, "R4 inactive then active sets pend");
  endtask

  task automatic t_irq_gate();
    do_reset();
    irq_en = 1'b0;
    pin_raw[6] = 1'b1; pin_en[6] = 1'b1;
    tick(4);
    pin_raw[6] = 1'b0;
    tick(3);
    chk(pend, 1'b1, "R6 pend set with irq disabled");
    chk(irq, 1'b0, "R6 irq masked");
    irq_en = 1'b1;
    #1;
    chk(irq, 1'b1, "R6 irq unmasked");
  endtask

  task automatic t_level_hold();
    do_reset();
    level_mode = 1'b1;
    pin_raw[2] = 1'b1; pin_en[2] = 1'b1;
    tick(4);
    pin_raw[2] = 1'b0;
    tick(3);
    chk(pend, 1'b1, "R7 level mode edge sets pend");
    pulse_ack();
    chk(pend, 1'b1, "R7 ack ignored while level held");
    pin_raw[2] = 1'b1;
    tick(3);
    pulse_ack();
    chk(pend, 1'b0, "R7 ack clears after release");
  endtask

  task automatic t_collision();
    do_reset();
    pin_raw[0] = 1'b1; pin_raw[1] = 1'b1; pin_en[1:0] = 2'b11;
    tick(4);
    pin_raw[0] = 1'b0;
    tick(3);
    chk(pend, 1'b1, "R8 first event");
    pin_raw[1] = 1'b0;
    tick(2);
    pulse_ack();
    chk(pend, 1'b1, "R8 edge wins over ack");
  endtask

  task automatic t_cfg_change();
    do_reset();
    pin_en[0] = 1'b1;
    tick(4);
    chk(pend, 1'b0, "R9 low pin at enable");
    pin_pol[0] = 1'b1;
    tick(4);
    chk(pend, 1'b0, "R9 polarity to 1");
    pin_pol[0] = 1'b0;
    tick(4);
    chk(pend, 1'b0, "R9 polarity back to 0 on low pin");
    pin_en[0] = 1'b0;
    tick(2);
    pin_en[0] = 1'b1;
    tick(4);
    chk(pend, 1'b0, "R9 re-enable on active pin");
  endtask

  initial begin
    t_reset_state();
    t_falling_latency();
    t_edge_ack();
    t_disabled();
    t_rising();
    t_already_active();
    t_irq_gate();
    t_level_hold();
    t_collision();
    t_cfg_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule